// File: doc/BRIEF.md
# Write Strobe Qualifier with Power-Up Lockout

This block stands between the external control pins of a non-volatile memory and its internal write engine. It watches an active-low chip enable, write enable and output enable, together with a single digital flag that says the supply is healthy. It emits a one-cycle `wr_start` pulse only when a real write strobe arrives and every guard condition allows it. Supply sensing itself is outside the block: the flag arrives already digitised.

The pins are asynchronous to the clock, so they pass through a synchroniser first. Three guards then apply, and each one alone can stop a write:
- **Lockout.** Once the supply flag goes high, a counter must run for a set number of clock cycles before writes are allowed. Any drop of the flag clears that counter.
- **Strobe level.** A strobe counts only while chip enable and write enable are both low and output enable is high.
- **Glitch filter.** The strobe must stay in that state for a minimum number of consecutive cycles.

Each strobe is judged once, on the cycle it reaches the minimum width. If that judgement blocks it, the strobe is spent: holding it longer cannot start a write. All control pins are plain level signals, and there is no handshake at either edge of the block.

Top module: `write_guard`

## Requirements
- R1: While reset is asserted and on the first cycle after reset, `wr_start` is 0.
- R2: While `supply_ok` is 0, no strobe of any length produces a pulse on `wr_start`.
- R3: After `supply_ok` rises, writes stay blocked until `supply_ok` has been seen high for `LOCKOUT_CYC` cycles. A strobe that qualifies inside that window gives no pulse, and one that qualifies well after it gives a pulse.
- R4: A drop of `supply_ok`, even a short one, restarts the lockout in full.
- R5: With `oe_n` at 0, a strobe (`ce_n`=0, `we_n`=0) gives no pulse.
- R6: With `ce_n` at 1, a low level on `we_n` gives no pulse.
- R7: With `we_n` at 1, a low level on `ce_n` gives no pulse.
- R8: A strobe (`ce_n`=0, `we_n`=0, `oe_n`=1) held for fewer than `MIN_PULSE` sampled cycles gives no pulse. A strobe held for exactly `MIN_PULSE` cycles gives one.
- R9: A qualifying strobe gives exactly one `wr_start` pulse, one cycle wide, however long it is held.
- R10: If the strobe is first driven just after rising edge c0, the pulse is high in the cycle after edge c0+`SYNC_STAGES`+`MIN_PULSE`.
- R11: A strobe that is blocked by the lockout when it reaches the minimum width stays spent. It gives no pulse even if the lockout ends while the strobe is still held.
- R12: A strobe broken for one cycle by any inhibit condition counts as two strobes. Each piece needs `MIN_PULSE` cycles of its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Supply-healthy flag, asynchronous |
| ce_n | input | 1 | Chip enable, active low, asynchronous |
| we_n | input | 1 | Write enable, active low, asynchronous |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| wr_start | output | 1 | One-cycle write-start pulse |

## Verification
The assertions assume the pin inputs are stable for at least one clock cycle around each change, so that the synchronised copies follow the pins without loss. The bench therefore changes pins only on falling edges and holds each level for whole cycles. The checks also assume that the lockout does not expire during the few cycles in which a strobe is reaching its minimum width. To respect this, the bench places every strobe that should be blocked, or should pass, far from the lockout boundary, at either well before it or several lockout lengths after it.

// File: rtl/wg_pkg.sv
package wg_pkg;
  // Qualifier state for one strobe
  typedef enum logic [1:0] {
    QS_IDLE  = 2'd0,  // no strobe present
    QS_COUNT = 2'd1,  // strobe present, width being measured
    QS_SPENT = 2'd2   // strobe already judged, wait for release
  } qual_state_t;

  // Synchronised pin bundle
  typedef struct packed {
    logic sup;
    logic ce_n;
    logic we_n;
    logic oe_n;
  } pins_t;

  localparam int PINS_W = $bits(pins_t);
  localparam pins_t PINS_RST = '{sup: 1'b0, ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1};
endpackage

// File: rtl/wg_sync.sv
module wg_sync #(
  parameter int W = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (STAGES == 0) begin : g_bypass
      assign q = d;
    end else begin : g_chain
      logic [W-1:0] stg [STAGES];
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[i] <= RST_VAL;
          else if (i == 0) stg[i] <= d;
          else stg[i] <= stg[(i > 0) ? i-1 : 0];
        end
      end
      assign q = stg[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/wg_lockout.sv
module wg_lockout #(
  parameter int LOCKOUT_CYC = 500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sup,
  output logic armed
);
  localparam int CW = $clog2(LOCKOUT_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(LOCKOUT_CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      armed <= 1'b0;
    end else if (!sup) begin
      cnt   <= '0;
      armed <= 1'b0;
    end else if (!armed) begin
      if (cnt == LAST) armed <= 1'b1;
      cnt <= cnt + 1'b1;
    end
  end

  AST_DROP_DISARMS: assert property (@(posedge clk) disable iff (!rst_n) !sup |=> !armed); // R4
  AST_ARM_NEEDS_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n) $rose(armed) |-> $past(sup)); // R3
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n) cnt <= CW'(LOCKOUT_CYC)); // R3
endmodule

// File: rtl/wg_qualify.sv
module wg_qualify
  import wg_pkg::*;
#(
  parameter int MIN_PULSE = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic act,
  input  logic allow,
  output logic start
);
  localparam int CW = $clog2(MIN_PULSE) + 1;
  localparam logic [CW-1:0] LAST = CW'(MIN_PULSE - 1);

  qual_state_t st;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= QS_IDLE;
      cnt   <= '0;
      start <= 1'b0;
    end else begin
      start <= 1'b0;
      if (!act) begin
        st  <= QS_IDLE;
        cnt <= '0;
      end else if (st != QS_SPENT) begin
        if (cnt == LAST) begin
          st    <= QS_SPENT;
          start <= allow;
        end else begin
          st  <= QS_COUNT;
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) start |=> !start); // R9
  AST_START_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n) start |-> $past(act)); // R8
  AST_START_NEEDS_ALLOW: assert property (@(posedge clk) disable iff (!rst_n) start |-> $past(allow)); // R3
  AST_SPENT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (st == QS_SPENT && act) |=> st == QS_SPENT); // R11
  AST_FILTER_BOUND: assert property (@(posedge clk) disable iff (!rst_n) cnt <= LAST); // R8
endmodule

// File: rtl/write_guard.sv
module write_guard
  import wg_pkg::*;
#(
  parameter int LOCKOUT_CYC = 500000,
  parameter int MIN_PULSE   = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  input  logic ce_n,
  input  logic we_n,
  input  logic oe_n,
  output logic wr_start
);
  pins_t raw, syn;
  logic  act, armed, allow;

  assign raw = '{sup: supply_ok, ce_n: ce_n, we_n: we_n, oe_n: oe_n};

  wg_sync #(.W(PINS_W), .STAGES(SYNC_STAGES), .RST_VAL(PINS_RST)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw), .q(syn)
  );

  wg_lockout #(.LOCKOUT_CYC(LOCKOUT_CYC)) u_lock (
    .clk(clk), .rst_n(rst_n), .sup(syn.sup), .armed(armed)
  );

  // Strobe present only with both enables low and output enable high
  always_comb begin
    act   = !syn.ce_n && !syn.we_n && syn.oe_n;
    allow = armed && syn.sup;
  end

  wg_qualify #(.MIN_PULSE(MIN_PULSE)) u_qual (
    .clk(clk), .rst_n(rst_n), .act(act), .allow(allow), .start(wr_start)
  );

  AST_NO_START_UNPOWERED: assert property (@(posedge clk) disable iff (!rst_n) wr_start |-> $past(syn.sup)); // R2
  AST_NO_START_OE_LOW: assert property (@(posedge clk) disable iff (!rst_n) wr_start |-> $past(syn.oe_n)); // R5
  AST_NO_START_CE_HIGH: assert property (@(posedge clk) disable iff (!rst_n) wr_start |-> !$past(syn.ce_n)); // R6
  AST_NO_START_WE_HIGH: assert property (@(posedge clk) disable iff (!rst_n) wr_start |-> !$past(syn.we_n)); // R7
endmodule

// File: tb/tb_write_guard.sv
module tb_write_guard;
  localparam int CLK_PERIOD = 10;
  localparam int LOCK = 40;
  localparam int MINP = 3;
  localparam int SYNC = 2;

  logic clk = 0, rst_n = 0;
  logic supply_ok = 0, ce_n = 1, we_n = 1, oe_n = 1;
  logic wr_start;
  int cyc = 0;
  int checks = 0, fails = 0;
  bit done = 0;
  int exp_cyc[$];
  string exp_tag[$];

  write_guard #(.LOCKOUT_CYC(LOCK), .MIN_PULSE(MINP), .SYNC_STAGES(SYNC)) dut (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .ce_n(ce_n), .we_n(we_n),
    .oe_n(oe_n), .wr_start(wr_start)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: pops expected pulse cycles and compares
  always @(negedge clk) begin
    if (rst_n && wr_start) begin
      checks++;
      if (exp_cyc.size() == 0) begin
        fails++;
        $display("FAIL unexpected pulse at cycle %0d (actual 1, expected 0)", cyc);
      end else begin
        int e;
        string t;
        e = exp_cyc.pop_front();
        t = exp_tag.pop_front();
        if (e != cyc) begin
          fails++;
          $display("FAIL %s pulse cycle actual %0d expected %0d", t, cyc, e);
        end
      end
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Driver: apply pin levels for n cycles, optionally push expected pulse
  task automatic seg(logic c, logic w, logic o, int n, bit expect_pulse, string tag);
    ce_n = c; we_n = w; oe_n = o;
    if (expect_pulse) begin
      exp_cyc.push_back(cyc + SYNC + MINP);
      exp_tag.push_back(tag);
    end
    idle(n);
  endtask

  task automatic release_pins();
    ce_n = 1; we_n = 1; oe_n = 1;
  endtask

  task automatic drain(string tag);
    idle(12);
    checks++;
    if (exp_cyc.size() != 0) begin
      fails++;
      $display("FAIL %s missing pulse: actual none expected at cycle %0d", tag, exp_cyc[0]);
      exp_cyc.delete();
      exp_tag.delete();
    end
  endtask

  task automatic strobe(int n, bit expect_pulse, string tag);
    seg(0, 0, 1, n, expect_pulse, tag);
    release_pins();
    drain(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired (actual hung, expected completion)");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    idle(3);
    checks++;
    if (wr_start !== 1'b0) begin fails++; $display("FAIL R1 in reset actual %b expected 0", wr_start); end
    rst_n = 1;
    @(negedge clk);
    checks++;
    if (wr_start !== 1'b0) begin fails++; $display("FAIL R1 after reset actual %b expected 0", wr_start); end

    // R2: no supply
    strobe(8, 0, "R2");

    // R3: during lockout blocked, afterwards allowed
    supply_ok = 1;
    idle(2);
    strobe(6, 0, "R3 inside lockout");
    idle(2 * LOCK);
    strobe(MINP, 1, "R3 after lockout");

    // R8: short strobe filtered, exact minimum passes
    strobe(MINP - 1, 0, "R8 short");
    strobe(1, 0, "R8 single");
    strobe(MINP, 1, "R8 exact");

    // R9 / R10: long strobe, one pulse at fixed latency
    strobe(30, 1, "R9 R10 long");

    // R5, R6, R7 inhibits
    strobe(0, 0, "R5 setup");
    seg(0, 0, 0, 10, 0, "R5"); release_pins(); drain("R5");
    seg(1, 0, 1, 10, 0, "R6"); release_pins(); drain("R6");
    seg(0, 1, 1, 10, 0, "R7"); release_pins(); drain("R7");

    // R12: strobe split by one inhibit cycle
    seg(0, 0, 1, MINP + 1, 1, "R12 first");
    seg(0, 0, 0, 1, 0, "R12 gap");
    seg(0, 0, 1, MINP + 1, 1, "R12 second");
    release_pins(); drain("R12");
    seg(0, 0, 1, MINP + 1, 1, "R12 first b");
    seg(0, 0, 1, 0, 0, "");
    ce_n = 1; idle(1);
    seg(0, 0, 1, MINP - 1, 0, "R12 short second");
    release_pins(); drain("R12 b");

    // R4: brief drop restarts lockout
    supply_ok = 0; idle(1); supply_ok = 1;
    idle(4);
    strobe(6, 0, "R4 after drop");
    idle(2 * LOCK);
    strobe(MINP, 1, "R4 rearmed");

    // R11: strobe spent during lockout, held past lockout end
    supply_ok = 0; idle(4); supply_ok = 1;
    idle(1);
    strobe(3 * LOCK, 0, "R11 held");
    strobe(MINP + 2, 1, "R11 fresh");

    // R2 again: supply removed after armed
    supply_ok = 0; idle(4);
    strobe(10, 0, "R2 dropped");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule